// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block turns a one-bit delta-sigma modulator stream into signed parallel samples. It uses a cascaded integrator-comb structure with five integrators and five combs. Each input bit counts as +1 or −1. The integrators run once for every modulator-rate enable. A decimation counter picks every N-th integrator value and passes it through the comb chain.

The comb result is divided by N^5, which gives the filter unity gain at DC. The result is then saturated into a 24-bit signed word in Q1.23 form, where full-scale positive is +1.0. A 3-bit rate field sets N to a power of two between 8 and 128.

A 2-bit mode field chooses the output. In bypass mode the raw modulator bits are forwarded with their own strobe and no filtered samples are produced. The other three mode codes all give the filtered samples, because the later filter stages are not part of this block. Any change of the rate field clears the filter and restarts its settling period.

Top module: `sinc5_decimator`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as −1. After settling, an all-ones stream gives `sample_out` = 0x7FFFFF, since +1.0 saturates. An all-zeros stream gives 0x800000, which is −1.0.
- R2: `rate_sel` codes 000, 001, 010, 011 and 100 select N = 128, 64, 32, 16 and 8. Once settled, `sample_valid` pulses once for every N accepted modulator bits.
- R3: `rate_sel` codes 101, 110 and 111 behave exactly like N = 128.
- R4: After reset or a restart, the first five decimated outputs are suppressed. The first `sample_valid` appears in the clock after the enable that delivers the 6·N-th bit.
- R5: A change of `rate_sel` clears the integrators, combs, decimation counter and settling count. No `sample_valid` appears in the cycle after the change, and the next one comes 6·N bits later.
- R6: With `mode_sel` = 00, `sample_valid` stays low. `bypass_valid` pulses one clock after each `mod_en`, and `bypass_bit` carries that bit.
- R7: `mode_sel` codes 01, 10 and 11 all output the same filtered samples, and `bypass_valid` stays low.
- R8: The gain is exactly 1/N^5. A repeating 1,1,1,0 stream settles to 0x400000, which is +0.5. A 1,0 stream settles to 0.
- R9: `sample_valid` lasts one clock and only follows a clock in which `mod_en` was high.
- R10: During and right after synchronous reset, `sample_out`, `sample_valid`, `bypass_valid` and `bypass_bit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Modulator-rate enable, one clock wide |
| mod_bit | input | 1 | Modulator output bit, taken when `mod_en` is high |
| rate_sel | input | 3 | Decimation ratio code |
| mode_sel | input | 2 | Output select: 00 bypass, others filtered |
| sample_out | output | 24 | Normalized filtered sample, Q1.23 |
| sample_valid | output | 1 | One-clock strobe for a new `sample_out` |
| bypass_bit | output | 1 | Forwarded modulator bit |
| bypass_valid | output | 1 | One-clock strobe for `bypass_bit` in bypass mode |

## Verification
The bench counts the bits delivered before the first strobe at every ratio, so an off-by-one settling count shows up as an early or late first sample. It also checks the strobe spacing, which exposes a wrong code-to-ratio map or wrong handling of an invalid code.

The fractional stream patterns test the normalization shift exactly. An error of one bit in the shift would halve or double the +0.5 result, and wrong saturation would corrupt the full-scale cases. The bench switches the rate in the middle of a stream to confirm that the filter restarts. It also exercises bypass mode to check that filtered strobes are gated off and that the forwarded bit matches the input.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;
    localparam int ORDER    = 5;
    localparam int MIN_LOG2 = 3;
    localparam int MAX_LOG2 = 7;
    localparam int OUT_W    = 24;
    localparam int ACC_W    = ORDER * MAX_LOG2 + 2;
    localparam int SCALE_W  = ACC_W + OUT_W - 1;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        MODE_RAW   = 2'b00,
        MODE_SINC  = 2'b01,
        MODE_NEXT1 = 2'b10,
        MODE_NEXT2 = 2'b11
    } mode_e;

    // Decimation exponent from the rate code; codes past the table fall back to the largest ratio.
    function automatic int ratio_exp(input logic [2:0] code);
        if (int'(code) <= MAX_LOG2 - MIN_LOG2)
            return MAX_LOG2 - int'(code);
        return MAX_LOG2;
    endfunction
endpackage

// File: rtl/sinc5_integrators.sv
module sinc5_integrators #(
    parameter int ORDER = 5,
    parameter int ACC_W = 37
) (
    input  logic                    clk,
    input  logic                    clear,
    input  logic                    step,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc_last
);
    logic signed [ACC_W-1:0] acc [ORDER];
    logic signed [ACC_W-1:0] x_in;

    assign x_in = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    genvar g;
    generate
        for (g = 0; g < ORDER; g++) begin : g_int
            always_ff @(posedge clk) begin
                if (clear)
                    acc[g] <= '0;
                else if (step) begin
                    if (g == 0)
                        acc[g] <= acc[g] + x_in;
                    else
                        acc[g] <= acc[g] + acc[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign acc_last = acc[ORDER-1];
endmodule

// File: rtl/sinc5_combs.sv
module sinc5_combs #(
    parameter int ORDER = 5,
    parameter int ACC_W = 37
) (
    input  logic                    clk,
    input  logic                    clear,
    input  logic                    tick,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] dly  [ORDER];
    logic signed [ACC_W-1:0] diff [ORDER];

    genvar g;
    generate
        for (g = 0; g < ORDER; g++) begin : g_comb
            logic signed [ACC_W-1:0] stage_in;
            if (g == 0) begin : g_first
                assign stage_in = din;
            end else begin : g_rest
                assign stage_in = diff[g-1];
            end
            assign diff[g] = stage_in - dly[g];
            always_ff @(posedge clk) begin
                if (clear)
                    dly[g] <= '0;
                else if (tick)
                    dly[g] <= stage_in;
            end
        end
    endgenerate

    assign dout = diff[ORDER-1];
endmodule

// File: rtl/sinc5_scale.sv
module sinc5_scale #(
    parameter int ORDER = 5,
    parameter int ACC_W = 37,
    parameter int OUT_W = 24
) (
    input  logic signed [ACC_W-1:0] comb_in,
    input  logic [3:0]              exp_n,
    output logic signed [OUT_W-1:0] norm_out
);
    localparam int WIDE_W = ACC_W + OUT_W - 1;
    localparam logic signed [WIDE_W-1:0] POS_LIM = WIDE_W'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam logic signed [WIDE_W-1:0] NEG_LIM = -(WIDE_W'(64'sd1 <<< (OUT_W-1)));

    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] shifted;
    logic [7:0]               sh;

    always_comb begin
        sh      = 8'(ORDER) * {4'd0, exp_n};
        wide    = {{(OUT_W-1){comb_in[ACC_W-1]}}, comb_in} <<< (OUT_W-1);
        shifted = wide >>> sh;
        if (shifted > POS_LIM)
            norm_out = POS_LIM[OUT_W-1:0];
        else if (shifted < NEG_LIM)
            norm_out = NEG_LIM[OUT_W-1:0];
        else
            norm_out = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
    import sinc5_pkg::*;
#(
    parameter int ORD    = ORDER,
    parameter int ACCW   = ACC_W,
    parameter int OUTW   = OUT_W,
    parameter int CNT_W  = MAX_LOG2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mod_en,
    input  logic                   mod_bit,
    input  logic [2:0]             rate_sel,
    input  logic [1:0]             mode_sel,
    output logic signed [OUTW-1:0] sample_out,
    output logic                   sample_valid,
    output logic                   bypass_bit,
    output logic                   bypass_valid
);
    localparam int WARM_W = $clog2(ORD + 1);

    logic [2:0]              rate_q;
    logic                    rate_chg;
    logic                    clear;
    logic [3:0]              exp_n;
    logic [CNT_W-1:0]        dec_cnt;
    logic [CNT_W-1:0]        cnt_lim;
    logic                    tick;
    logic [WARM_W-1:0]       warm_cnt;
    logic signed [ACCW-1:0]  int_out;
    logic signed [ACCW-1:0]  comb_out;
    logic signed [OUTW-1:0]  norm;
    mode_e                   mode;

    assign mode     = mode_e'(mode_sel);
    assign rate_chg = (rate_sel != rate_q);
    assign clear    = rst || rate_chg;
    assign exp_n    = 4'(ratio_exp(rate_q));
    assign cnt_lim  = CNT_W'((32'd1 << exp_n) - 32'd1);
    assign tick     = mod_en && (dec_cnt == cnt_lim);

    sinc5_integrators #(.ORDER(ORD), .ACC_W(ACCW)) u_int (
        .clk(clk), .clear(clear), .step(mod_en), .bit_in(mod_bit), .acc_last(int_out)
    );

    sinc5_combs #(.ORDER(ORD), .ACC_W(ACCW)) u_comb (
        .clk(clk), .clear(clear), .tick(tick), .din(int_out), .dout(comb_out)
    );

    sinc5_scale #(.ORDER(ORD), .ACC_W(ACCW), .OUT_W(OUTW)) u_scale (
        .comb_in(comb_out), .exp_n(exp_n), .norm_out(norm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q       <= rate_sel;
            dec_cnt      <= '0;
            warm_cnt     <= '0;
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else if (rate_chg) begin
            rate_q       <= rate_sel;
            dec_cnt      <= '0;
            warm_cnt     <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (mod_en)
                dec_cnt <= tick ? '0 : dec_cnt + 1'b1;
            if (tick) begin
                if (warm_cnt == WARM_W'(ORD)) begin
                    sample_out   <= norm;
                    sample_valid <= (mode != MODE_RAW);
                end else begin
                    warm_cnt <= warm_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_bit   <= 1'b0;
            bypass_valid <= 1'b0;
        end else begin
            bypass_valid <= mod_en && (mode == MODE_RAW);
            if (mod_en)
                bypass_bit <= mod_bit;
        end
    end
endmodule

// File: rtl/sinc5_decimator_chk.sv
module sinc5_decimator_chk (
    input logic       clk,
    input logic       rst,
    input logic       mod_en,
    input logic       mod_bit,
    input logic [2:0] rate_sel,
    input logic [1:0] mode_sel,
    input logic       sample_valid,
    input logic       bypass_bit,
    input logic       bypass_valid
);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    assert_after_enable_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(mod_en));

    assert_raw_gates_samples_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && $past(mode_sel) == 2'b00) |-> !sample_valid);

    assert_raw_bit_follows_R6: assert property (@(posedge clk) disable iff (rst)
        bypass_valid |-> ($past(mod_en) && bypass_bit == $past(mod_bit)));

    assert_filtered_no_raw_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) != 2'b00) |-> !bypass_valid);

    assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> !sample_valid);
endmodule

bind sinc5_decimator sinc5_decimator_chk u_chk (
    .clk(clk), .rst(rst), .mod_en(mod_en), .mod_bit(mod_bit),
    .rate_sel(rate_sel), .mode_sel(mode_sel), .sample_valid(sample_valid),
    .bypass_bit(bypass_bit), .bypass_valid(bypass_valid)
);

// File: tb/sinc5_decimator_test.sv
module sinc5_decimator_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic [1:0]  mode_sel = 2'b01;
    logic signed [23:0] sample_out;
    logic        sample_valid;
    logic        bypass_bit;
    logic        bypass_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // stream statistics
    int n_valid, first_at, bad_val, bad_gap, n_byp, bad_byp, last_clk, bits_sent;
    logic signed [23:0] bad_sample;
    logic last_bit;

    sinc5_decimator uut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .mod_bit(mod_bit),
        .rate_sel(rate_sel), .mode_sel(mode_sel), .sample_out(sample_out),
        .sample_valid(sample_valid), .bypass_bit(bypass_bit), .bypass_valid(bypass_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mod_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Feed nbits bits (one enable every 4 clocks) and gather statistics.
    task automatic stream(input int nbits, input logic [7:0] pat, input int plen,
                          input int n, input logic signed [23:0] exp_val);
        int clk_i = 0;
        n_valid = 0; first_at = -1; bad_val = 0; bad_gap = 0;
        n_byp = 0; bad_byp = 0; last_clk = -1; bits_sent = 0; bad_sample = '0;
        for (int b = 0; b < nbits + 1; b++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                clk_i++;
                if (sample_valid) begin
                    if (n_valid == 0) first_at = bits_sent;
                    if (sample_out != exp_val) begin bad_val++; bad_sample = sample_out; end
                    if (last_clk >= 0 && clk_i - last_clk != 4*n) bad_gap++;
                    last_clk = clk_i;
                    n_valid++;
                end
                if (bypass_valid) begin
                    n_byp++;
                    if (bypass_bit != last_bit) bad_byp++;
                end
                mod_en = (c == 3) && (b < nbits);
                if (mod_en) begin
                    mod_bit  = pat[bits_sent % plen];
                    last_bit = mod_bit;
                    bits_sent++;
                end
            end
        end
        @(negedge clk);
        mod_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R10 sample_out", sample_out == 0, sample_out, 0);
        check("R10 strobes", {sample_valid, bypass_valid, bypass_bit} == 3'b000,
              {sample_valid, bypass_valid, bypass_bit}, 0);
    endtask

    task automatic t_rate(input logic [2:0] code, input int n);
        rate_sel = code; mode_sel = 2'b01;
        do_reset();
        stream(8*n, 8'hFF, 1, n, 24'sh7FFFFF);
        check("R4 first valid bit count", first_at == 6*n, first_at, 6*n);
        check("R2 strobe spacing", bad_gap == 0 && n_valid == 3, n_valid, 3);
        check("R1 full scale positive", bad_val == 0, bad_sample, 24'sh7FFFFF);
    endtask

    task automatic t_invalid(input logic [2:0] code);
        rate_sel = code; mode_sel = 2'b01;
        do_reset();
        stream(7*128, 8'hFF, 1, 128, 24'sh7FFFFF);
        check("R3 invalid code first valid", first_at == 768, first_at, 768);
        check("R3 invalid code spacing", bad_gap == 0 && n_valid == 2, n_valid, 2);
    endtask

    task automatic t_negative();
        rate_sel = 3'd4; mode_sel = 2'b01;
        do_reset();
        stream(80, 8'h00, 1, 8, -24'sh800000);
        check("R1 full scale negative", bad_val == 0 && n_valid == 5, bad_sample, -24'sh800000);
    endtask

    task automatic t_fraction(input logic [1:0] mode, input logic [2:0] code, input int n);
        rate_sel = code; mode_sel = mode;
        do_reset();
        stream(8*n, 8'b0111_0111, 4, n, 24'sh400000);
        check("R8 three quarter density", bad_val == 0 && n_valid == 3, bad_sample, 24'sh400000);
        check("R7 no raw strobes in filtered mode", n_byp == 0, n_byp, 0);
    endtask

    task automatic t_alternate();
        rate_sel = 3'd2; mode_sel = 2'b01;
        do_reset();
        stream(8*32, 8'b0101_0101, 2, 32, 24'sh0);
        check("R8 alternating is zero", bad_val == 0 && n_valid == 3, bad_sample, 0);
    endtask

    task automatic t_bypass();
        rate_sel = 3'd4; mode_sel = 2'b00;
        do_reset();
        stream(100, 8'b0110_1001, 8, 8, 24'sh0);
        check("R6 no filtered strobe", n_valid == 0, n_valid, 0);
        check("R6 raw strobe count", n_byp == 100, n_byp, 100);
        check("R6 raw bit matches", bad_byp == 0, bad_byp, 0);
    endtask

    task automatic t_restart();
        rate_sel = 3'd3; mode_sel = 2'b01;
        do_reset();
        stream(120, 8'h00, 1, 16, -24'sh800000);
        check("R5 before change", n_valid >= 1, n_valid, 1);
        @(negedge clk);
        rate_sel = 3'd4;
        stream(80, 8'hFF, 1, 8, 24'sh7FFFFF);
        check("R5 restart settling", first_at == 48, first_at, 48);
        check("R5 restart value", bad_val == 0 && n_valid == 5, bad_sample, 24'sh7FFFFF);
    endtask

    initial begin
        t_reset_state();
        t_rate(3'd0, 128);
        t_rate(3'd1, 64);
        t_rate(3'd2, 32);
        t_rate(3'd3, 16);
        t_rate(3'd4, 8);
        t_invalid(3'd5);
        t_invalid(3'd7);
        t_negative();
        t_fraction(2'b01, 3'd3, 16);
        t_fraction(2'b10, 3'd4, 8);
        t_fraction(2'b11, 3'd2, 32);
        t_alternate();
        t_bypass();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule